// File: doc/BRIEF.md
# Condition-Gated Flag ALU

This block is a single-cycle execute stage for 32-bit integer operations. Each request brings an operation code, two operands, a 4-bit condition selector, a set-flags bit and a valid strobe. The block holds four status flags: negative, zero, carry and overflow. On each clock edge it tests the selected condition against the flags it holds at that moment. If the condition holds, the operation takes effect. If it does not, the request is dropped, as though it had never been presented.

Operations split into two groups. Data operations (AND, OR, XOR, add, subtract) produce a result and a write-enable pulse. They change the flags only when the set-flags bit is high. Comparison operations (compare, compare-negative, test, test-equivalence) always update the flags and never produce a write. The flags sit in the top four bits of a 32-bit status word.

Top module: `cond_alu`

## Requirements
- R1: While `rst` is high, and at the first edge after it, `out_status`, `out_result` and `out_wr_en` are all zero.
- R2: `out_status` places N in bit 31, Z in bit 30, C in bit 29 and V in bit 28; bits 27 to 0 always read zero.
- R3: Opcodes 0 AND, 1 XOR, 4 OR, 3 ADD (a+b) and 2 SUB (a-b) are data operations. When one executes at an edge, `out_result` takes the value and `out_wr_en` is high for the following cycle. Otherwise `out_wr_en` is low and `out_result` holds.
- R4: A data operation changes the flags only when `in_setf` is 1. Then N is the result's bit 31 and Z is set when the result is zero. For ADD, C is the carry out and V is signed overflow. For SUB, C is set when no borrow occurs (a >= b unsigned) and V is signed overflow. For AND, OR and XOR, C and V keep their values.
- R5: Opcodes 5 CMP (a-b), 6 CMN (a+b), 7 TST (a AND b) and 8 TEQ (a XOR b) update the flags whatever the value of `in_setf`. They follow the R4 flag rules for their arithmetic or logical kind and never assert `out_wr_en`.
- R6: The condition selector is encoded as 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0, 8 C=1 and Z=0, 9 C=0 or Z=1, 10 N=V, 11 N!=V, 12 Z=0 and N=V, 13 Z=1 or N!=V, 14 always, 15 never.
- R7: When the condition fails, `out_wr_en` stays low and the flags are unchanged, even with `in_setf` set.
- R8: With `in_valid` low, or with an opcode of 9 to 15, nothing changes: no write, and the flags and result are held.
- R9: The condition is tested against the flags held before the edge, so a request sees the flags written by the request just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 4 | Operation code |
| in_cond | input | 4 | Condition selector |
| in_setf | input | 1 | Set-flags request for data operations |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_result | output | 32 | Last written result |
| out_wr_en | output | 1 | High for one cycle after a data operation executes |
| out_status | output | 32 | Status word with flags in bits 31 to 28 |

## Verification
The assertions check on every cycle that the low status bits stay zero. They also check that an idle, undefined or condition-failing request leaves the flags and the write strobe alone, that comparisons never write, and that a data operation without set-flags leaves the flags stable. Only the bench's scenarios can show that the flag values themselves are right: carry as no-borrow on subtraction, overflow at the signed limits, and C and V held across logical operations. The scenarios also show that all sixteen condition codes decide correctly against flag states set up by earlier comparisons.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

    typedef enum logic [3:0] {
        OPC_AND = 4'd0,
        OPC_EOR = 4'd1,
        OPC_SUB = 4'd2,
        OPC_ADD = 4'd3,
        OPC_ORR = 4'd4,
        OPC_CMP = 4'd5,
        OPC_CMN = 4'd6,
        OPC_TST = 4'd7,
        OPC_TEQ = 4'd8
    } opc_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cc_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    localparam int unsigned FLAG_BITS = 4;

    function automatic logic cc_holds(input logic [3:0] cc, input flags_t f);
        logic r;
        case (cc_e'(cc))
            CC_EQ:   r = f.z;
            CC_NE:   r = !f.z;
            CC_CS:   r = f.c;
            CC_CC:   r = !f.c;
            CC_MI:   r = f.n;
            CC_PL:   r = !f.n;
            CC_VS:   r = f.v;
            CC_VC:   r = !f.v;
            CC_HI:   r = f.c && !f.z;
            CC_LS:   r = !f.c || f.z;
            CC_GE:   r = (f.n == f.v);
            CC_LT:   r = (f.n != f.v);
            CC_GT:   r = !f.z && (f.n == f.v);
            CC_LE:   r = f.z || (f.n != f.v);
            CC_AL:   r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic op_known(input logic [3:0] op);
        return op <= OPC_TEQ;
    endfunction

    function automatic logic op_is_test(input logic [3:0] op);
        return (op >= OPC_CMP) && (op <= OPC_TEQ);
    endfunction

    function automatic logic op_is_arith(input logic [3:0] op);
        return (op == OPC_SUB) || (op == OPC_ADD) || (op == OPC_CMP) || (op == OPC_CMN);
    endfunction

    function automatic logic op_is_sub(input logic [3:0] op);
        return (op == OPC_SUB) || (op == OPC_CMP);
    endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import cond_alu_pkg::*;
(
    input  logic [3:0] cc,
    input  flags_t     flags,
    output logic       pass
);
    always_comb pass = cc_holds(cc, flags);
endmodule

// File: rtl/alu_core.sv
module alu_core
    import cond_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             c_prev,
    input  logic             v_prev,
    output logic [WIDTH-1:0] res,
    output flags_t           nxt
);
    localparam int unsigned MSB = WIDTH - 1;

    logic             sub_sel;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   sum;
    logic             arith;
    logic [WIDTH-1:0] logic_res;

    always_comb begin
        sub_sel = op_is_sub(op);
        arith   = op_is_arith(op);
        b_eff   = sub_sel ? ~b : b;
        sum     = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_sel};
        case (op)
            OPC_AND, OPC_TST: logic_res = a & b;
            OPC_EOR, OPC_TEQ: logic_res = a ^ b;
            default:          logic_res = a | b;
        endcase
        res   = arith ? sum[MSB:0] : logic_res;
        nxt.n = res[MSB];
        nxt.z = (res == '0);
        nxt.c = arith ? sum[WIDTH] : c_prev;
        nxt.v = arith ? ((a[MSB] == b_eff[MSB]) && (res[MSB] != a[MSB])) : v_prev;
    end
endmodule

// File: rtl/status_reg.sv
module status_reg
    import cond_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  flags_t           nxt,
    output flags_t           cur,
    output logic [WIDTH-1:0] word
);
    localparam int unsigned PAD = WIDTH - FLAG_BITS;

    always_ff @(posedge clk) begin
        if (rst)       cur <= '0;
        else if (load) cur <= nxt;
    end

    generate
        if (PAD > 0) begin : g_pad
            assign word = {cur, {PAD{1'b0}}};
        end else begin : g_nopad
            assign word = cur;
        end
    endgenerate
endmodule

// File: rtl/cond_alu.sv
module cond_alu
    import cond_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [3:0]       in_op,
    input  logic [3:0]       in_cond,
    input  logic             in_setf,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] out_result,
    output logic             out_wr_en,
    output logic [WIDTH-1:0] out_status
);
    flags_t           flg_cur;
    flags_t           flg_nxt;
    logic             cond_ok;
    logic             fire;
    logic             do_write;
    logic             do_flags;
    logic [WIDTH-1:0] alu_res;

    cond_eval u_cond (
        .cc    (in_cond),
        .flags (flg_cur),
        .pass  (cond_ok)
    );

    alu_core #(.WIDTH(WIDTH)) u_alu (
        .op     (in_op),
        .a      (in_a),
        .b      (in_b),
        .c_prev (flg_cur.c),
        .v_prev (flg_cur.v),
        .res    (alu_res),
        .nxt    (flg_nxt)
    );

    always_comb begin
        fire     = in_valid && op_known(in_op) && cond_ok;
        do_write = fire && !op_is_test(in_op);
        do_flags = fire && (in_setf || op_is_test(in_op));
    end

    status_reg #(.WIDTH(WIDTH)) u_stat (
        .clk  (clk),
        .rst  (rst),
        .load (do_flags),
        .nxt  (flg_nxt),
        .cur  (flg_cur),
        .word (out_status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_result <= '0;
            out_wr_en  <= 1'b0;
        end else begin
            out_wr_en <= do_write;
            if (do_write) out_result <= alu_res;
        end
    end
endmodule

// File: rtl/cond_alu_chk.sv
module cond_alu_chk
    import cond_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [3:0]       in_op,
    input logic [3:0]       in_cond,
    input logic             in_setf,
    input logic [WIDTH-1:0] out_result,
    input logic             out_wr_en,
    input logic [WIDTH-1:0] out_status
);
    localparam int unsigned PAD = WIDTH - FLAG_BITS;

    flags_t seen;
    assign seen = out_status[WIDTH-1 -: FLAG_BITS];

    p_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
        out_status[PAD-1:0] == '0);

    p_fail_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_known(in_op) && !cc_holds(in_cond, seen))
        |=> (!out_wr_en && $stable(out_status)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || !op_known(in_op)) |=> (!out_wr_en && $stable(out_status)));

    p_test_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_is_test(in_op)) |=> !out_wr_en);

    p_noflag_data_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_known(in_op) && !op_is_test(in_op) && !in_setf)
        |=> $stable(out_status));

    p_result_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !out_wr_en |-> $stable(out_result));

    p_nz_match_r4: assert property (@(posedge clk) disable iff (rst)
        (out_wr_en && $past(in_setf))
        |-> (seen.z == (out_result == '0) && seen.n == out_result[WIDTH-1]));
endmodule

bind cond_alu cond_alu_chk #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_cond    (in_cond),
    .in_setf    (in_setf),
    .out_result (out_result),
    .out_wr_en  (out_wr_en),
    .out_status (out_status)
);

// File: tb/cond_alu_tb_top.sv
module cond_alu_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [3:0]  in_cond = '0;
    logic        in_setf = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic [31:0] out_result;
    logic        out_wr_en;
    logic [31:0] out_status;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    bit        m_n, m_z, m_c, m_v;
    bit [31:0] m_res;
    bit        m_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_alu dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_cond(in_cond), .in_setf(in_setf), .in_a(in_a), .in_b(in_b),
        .out_result(out_result), .out_wr_en(out_wr_en), .out_status(out_status)
    );

    function automatic bit m_cond(int cc);
        case (cc)
            0: return m_z == 1;
            1: return m_z == 0;
            2: return m_c == 1;
            3: return m_c == 0;
            4: return m_n == 1;
            5: return m_n == 0;
            6: return m_v == 1;
            7: return m_v == 0;
            8: return (m_c == 1) && (m_z == 0);
            9: return (m_c == 0) || (m_z == 1);
            10: return m_n == m_v;
            11: return m_n != m_v;
            12: return (m_z == 0) && (m_n == m_v);
            13: return (m_z == 1) || (m_n != m_v);
            14: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic compare(string tag);
        bit [31:0] exp_st;
        exp_st = {m_n, m_z, m_c, m_v, 28'h0};
        vectors++;
        if (out_status !== exp_st || out_wr_en !== m_we || out_result !== m_res) begin
            misses++;
            $display("FAIL %s: status=%h we=%b res=%h expected status=%h we=%b res=%h",
                     tag, out_status, out_wr_en, out_result, exp_st, m_we, m_res);
        end
    endtask

    task automatic step(string tag, bit v, int op, int cc, bit s, bit [31:0] a, bit [31:0] b);
        longint sa, sb, sr;
        bit [32:0] wide;
        bit [31:0] r;
        bit arith, upd;
        @(negedge clk);
        in_valid = v; in_op = op[3:0]; in_cond = cc[3:0]; in_setf = s; in_a = a; in_b = b;
        m_we = 0;
        if (v && op <= 8 && m_cond(cc)) begin
            sa = longint'($signed(a)); sb = longint'($signed(b));
            arith = 0; wide = '0; sr = 0;
            case (op)
                0, 7: r = a & b;
                1, 8: r = a ^ b;
                4:    r = a | b;
                2, 5: begin arith = 1; r = a - b; wide = {1'b0, a} - {1'b0, b}; sr = sa - sb; end
                default: begin arith = 1; r = a + b; wide = {1'b0, a} + {1'b0, b}; sr = sa + sb; end
            endcase
            upd = s || (op >= 5);
            if (upd) begin
                m_n = r[31];
                m_z = (r == 0);
                if (arith) begin
                    m_c = (op == 2 || op == 5) ? (a >= b) : wide[32];
                    m_v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
                end
            end
            if (op < 5) begin m_res = r; m_we = 1; end
        end
        @(posedge clk); #1;
        compare(tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog (all requirements): run still active, expected finished");
            summary();
        end
    end

    initial begin
        m_n = 0; m_z = 0; m_c = 0; m_v = 0; m_res = 0; m_we = 0;
        repeat (3) @(posedge clk);
        #1; compare("R1 reset held");
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1; compare("R1 first edge after reset");

        // R3 plain data operations, no flags (R4)
        step("R3 AND", 1, 0, 14, 0, 32'h0000_0006, 32'h0000_000C);
        step("R3 XOR", 1, 1, 14, 0, 32'h0000_000A, 32'h0000_0007);
        step("R3 OR",  1, 4, 14, 0, 32'h0000_000E, 32'h0000_0003);
        step("R3 ADD", 1, 3, 14, 0, 32'hFFFF_FFFF, 32'h0000_0001);
        step("R4 SUB no setf keeps flags", 1, 2, 14, 0, 32'h5, 32'h5);
        // R4 flag results
        step("R4 SUBS equal Z C", 1, 2, 14, 1, 32'h5, 32'h5);
        step("R4 SUBS borrow N", 1, 2, 14, 1, 32'h3, 32'h5);
        step("R4 ADDS overflow N V", 1, 3, 14, 1, 32'h7FFF_FFFF, 32'h1);
        step("R4 logical keeps C V", 1, 0, 14, 1, 32'hF0, 32'h0F);
        step("R4 ADDS carry Z C", 1, 3, 14, 1, 32'hFFFF_FFFF, 32'h1);
        step("R4 SUBS signed overflow", 1, 2, 14, 1, 32'h8000_0000, 32'h1);
        // R5 comparisons ignore setf, never write
        step("R5 CMP", 1, 5, 14, 0, 32'h2, 32'h9);
        step("R5 CMN", 1, 6, 14, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        step("R5 TST zero", 1, 7, 14, 0, 32'hF0, 32'h0F);
        step("R5 TEQ equal", 1, 8, 14, 1, 32'h1234, 32'h1234);
        // R7 failing condition with setf
        step("R7 NV with setf", 1, 2, 15, 1, 32'h0, 32'h1);
        step("R7 NE while Z set", 1, 3, 1, 1, 32'h1, 32'h1);
        // R8 idle and undefined opcode
        step("R8 valid low", 0, 2, 14, 1, 32'h0, 32'h1);
        step("R8 undefined op", 1, 11, 14, 1, 32'h0, 32'h1);
        // R6 sweep of every condition over four flag states
        for (int st = 0; st < 4; st++) begin
            for (int cc = 0; cc < 16; cc++) begin
                case (st)
                    0: step("R6 setup Z C", 1, 5, 14, 0, 32'h5, 32'h5);
                    1: step("R6 setup N", 1, 5, 14, 0, 32'h3, 32'h5);
                    2: step("R6 setup N V", 1, 6, 14, 0, 32'h7FFF_FFFF, 32'h1);
                    default: step("R6 setup C only", 1, 5, 14, 0, 32'h9, 32'h2);
                endcase
                step("R6 condition gate", 1, 3, cc, 0, cc, 32'h100);
            end
        end
        // R9 back-to-back: second sees first's flags
        step("R9 set Z", 1, 5, 14, 0, 32'h7, 32'h7);
        step("R9 EQ sees Z", 1, 3, 0, 1, 32'h1, 32'h1);
        step("R9 EQ after clear", 1, 3, 0, 0, 32'h2, 32'h2);
        // random mix covering R3 R4 R5 R7 R8
        for (int i = 0; i < 3000; i++) begin
            step("R3/R4 random mix", ($urandom % 10) != 0, $urandom % 16, $urandom % 16,
                 $urandom % 2, (i % 7 == 0) ? 32'h8000_0000 : $urandom,
                 (i % 5 == 0) ? 32'h7FFF_FFFF : $urandom);
        end
        step("R2 final idle", 0, 0, 14, 0, 32'h0, 32'h0);
        done = 1;
        summary();
    end
endmodule